// File: doc/BRIEF.md
# Predicated Vector Element Issue Sequencer

This block expands one arithmetic instruction, written with ordinary scalar register numbers, into a run of element operations over the standard integer register file. On a start pulse it captures the destination and two source register numbers, a global vector length, the destination's own vector length, a per-register map that marks which registers are treated as vectors, and a predicate bitmask taken from an integer register. It then issues one element operation per clock cycle to a downstream adder and write port.

Each issued operation carries the element number, the destination and source register indices, and a write enable. An operand's index steps forward by one per element only when its base register is marked as a vector. Otherwise the operand stays on its base register. This one mechanism therefore covers the scalar-scalar, scalar-vector and vector-vector forms. Elements whose predicate bit is clear still take their cycle, but they carry no write enable, so the destination keeps its old contents rather than being cleared. The consumer writes the sum of the two source registers into the destination index whenever the write enable is high.

Top module: `vec_issue_seq`

## Requirements
- R1: After an accepted start, element operations appear on consecutive cycles, starting the cycle after the start edge, with `op_idx` counting 0, 1, ... n-1. n is the smaller of `vl` and `dst_vl`.
- R2: The element count is capped at XLEN (32). A length of 40 or 63 gives exactly 32 elements.
- R3: `op_wen` for element i equals bit i of `pred_mask`, where bit 0 belongs to element 0.
- R4: An element whose predicate bit is clear is issued with `op_wen` low, so its destination register is left unchanged and is never zeroed.
- R5: `op_rd` for element i is `rd + i` modulo 32 when bit `rd` of `vec_map` is set, and `rd` on every element otherwise.
- R6: `op_rs1` and `op_rs2` follow the same rule as R5, each using its own base register's bit in `vec_map`. Index 31 wraps to 0.
- R7: `vec_map` and `pred_mask` are sampled only at an accepted start. Changing them during a run does not alter the issued operations.
- R8: `done` is high for exactly one cycle: the cycle after the last element, with `op_valid` low.
- R9: A run of length zero issues no operation and raises `done` in the cycle after the start edge.
- R10: A `start` that arrives while elements are being issued is ignored, together with its operands.
- R11: A `start` in the same cycle as `done` is accepted, and its first element follows in the next cycle.
- R12: During and after reset, `op_valid`, `op_wen` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; ignored while a run is issuing |
| rd | input | 5 | Destination base register |
| rs1 | input | 5 | First source base register |
| rs2 | input | 5 | Second source base register |
| vl | input | 6 | Global vector length |
| dst_vl | input | 6 | Vector length of the destination register |
| vec_map | input | 32 | Bit k set marks register k as a vector |
| pred_mask | input | 32 | Predicate bits, bit i belongs to element i |
| op_valid | output | 1 | An element operation is being issued |
| op_wen | output | 1 | Write enable for the issued element |
| op_idx | output | 5 | Element number |
| op_rd | output | 5 | Destination register index |
| op_rs1 | output | 5 | First source register index |
| op_rs2 | output | 5 | Second source register index |
| done | output | 1 | One-cycle pulse after the run ends |

## Verification
Two events can fall in the same cycle: the completion pulse of one run and the start of the next. The bench provokes this by driving `start` with new operands in exactly the cycle where `done` is high. It then judges the following cycle, which must carry element 0 of the new run with the new indices. A second overlap is a `start` raised in the middle of a run while the vector map and predicate inputs are inverted at the same moment. The bench checks that this neither restarts the run nor changes any issued index or write enable.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
    localparam int XLEN  = 32;
    localparam int NREG  = 32;
    localparam int REG_W = $clog2(NREG);
    localparam int VL_W  = $clog2(XLEN + 1);
    localparam int IDX_W = $clog2(XLEN);
    localparam int NOPD  = 3;

    typedef logic [REG_W-1:0] reg_t;
    typedef logic [VL_W-1:0]  vlen_t;

    typedef struct packed {
        reg_t base;
        logic vec;
    } operand_t;

    function automatic vlen_t run_length(vlen_t a, vlen_t b);
        vlen_t m;
        m = (a < b) ? a : b;
        if (m > vlen_t'(XLEN)) m = vlen_t'(XLEN);
        return m;
    endfunction
endpackage

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
    import vseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  vlen_t len,
    output logic  accept,
    output logic  active,
    output vlen_t idx,
    output logic  done
);
    vlen_t last_q;

    assign accept = start & ~active;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
            last_q <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                idx    <= '0;
                last_q <= len - 1'b1;
                active <= (len != '0);
                done   <= (len == '0);
            end else if (active) begin
                if (idx == last_q) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    // R9
    zero_len_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && len == '0) |=> (done && !active));
    // R8
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> done);
    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !active);
    // R1
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !$past(accept) && $past(active)) |-> idx == $past(idx) + 1'b1);
endmodule

// File: rtl/vseq_operand_walk.sv
module vseq_operand_walk
    import vseq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  logic     step,
    input  operand_t opd,
    output reg_t     cur
);
    operand_t opd_q;
    reg_t     off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            opd_q <= '0;
            off_q <= '0;
        end else if (load) begin
            opd_q <= opd;
            off_q <= '0;
        end else if (step && opd_q.vec) begin
            off_q <= off_q + 1'b1;
        end
    end

    assign cur = opd_q.base + off_q;

    // R5
    scalar_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !opd_q.vec) |=> cur == $past(cur));
    // R6
    vector_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load && opd_q.vec) |=> cur == reg_t'($past(cur) + 1'b1));
endmodule

// File: rtl/vec_issue_seq.sv
module vec_issue_seq
    import vseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [REG_W-1:0] rd,
    input  logic [REG_W-1:0] rs1,
    input  logic [REG_W-1:0] rs2,
    input  logic [VL_W-1:0]  vl,
    input  logic [VL_W-1:0]  dst_vl,
    input  logic [NREG-1:0]  vec_map,
    input  logic [XLEN-1:0]  pred_mask,
    output logic             op_valid,
    output logic             op_wen,
    output logic [IDX_W-1:0] op_idx,
    output logic [REG_W-1:0] op_rd,
    output logic [REG_W-1:0] op_rs1,
    output logic [REG_W-1:0] op_rs2,
    output logic             done
);
    logic            accept, active;
    vlen_t           idx;
    logic [XLEN-1:0] pred_q;
    reg_t            bases [NOPD];
    reg_t            curs  [NOPD];

    assign bases[0] = rd;
    assign bases[1] = rs1;
    assign bases[2] = rs2;

    vseq_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .len    (run_length(vl, dst_vl)),
        .accept (accept),
        .active (active),
        .idx    (idx),
        .done   (done)
    );

    for (genvar g = 0; g < NOPD; g++) begin : g_opd
        operand_t opd_in;
        assign opd_in.base = bases[g];
        assign opd_in.vec  = vec_map[bases[g]];
        vseq_operand_walk u_walk (
            .clk  (clk),
            .rst  (rst),
            .load (accept),
            .step (active),
            .opd  (opd_in),
            .cur  (curs[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)         pred_q <= '0;
        else if (accept) pred_q <= pred_mask;
    end

    assign op_valid = active;
    assign op_idx   = idx[IDX_W-1:0];
    assign op_wen   = active & pred_q[idx[IDX_W-1:0]];
    assign op_rd    = curs[0];
    assign op_rs1   = curs[1];
    assign op_rs2   = curs[2];

    // R4
    wen_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        op_wen |-> op_valid);
    // R2
    idx_cap_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |-> idx < vlen_t'(XLEN));
    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && start && op_idx == '0) |=> !(op_valid && op_idx == '0));
endmodule

// File: tb/vec_issue_seq_test.sv
module vec_issue_seq_test;
    typedef struct packed {
        logic [4:0]  rd, rs1, rs2;
        logic [5:0]  vl, dvl;
        logic [31:0] vmap, pred;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t TBL [NV] = '{
        '{5'd4,  5'd8,  5'd12, 6'd4,  6'd4,  32'h0000_1110, 32'hFFFF_FFFF},
        '{5'd10, 5'd3,  5'd20, 6'd6,  6'd8,  32'h0010_0400, 32'h0000_002D},
        '{5'd5,  5'd6,  5'd7,  6'd3,  6'd3,  32'h0000_0000, 32'h0000_0007},
        '{5'd30, 5'd29, 5'd1,  6'd5,  6'd9,  32'h6000_0000, 32'h0000_001F},
        '{5'd0,  5'd1,  5'd2,  6'd40, 6'd63, 32'h0000_0001, 32'hFFFF_FFFF},
        '{5'd16, 5'd17, 5'd18, 6'd12, 6'd2,  32'h0001_0000, 32'h0000_0002}
    };

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [4:0] rd = '0, rs1 = '0, rs2 = '0;
    logic [5:0] vl = '0, dst_vl = '0;
    logic [31:0] vec_map = '0, pred_mask = '0;
    logic op_valid, op_wen, done;
    logic [4:0] op_idx, op_rd, op_rs1, op_rs2;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    vec_issue_seq uut (
        .clk(clk), .rst(rst), .start(start), .rd(rd), .rs1(rs1), .rs2(rs2),
        .vl(vl), .dst_vl(dst_vl), .vec_map(vec_map), .pred_mask(pred_mask),
        .op_valid(op_valid), .op_wen(op_wen), .op_idx(op_idx), .op_rd(op_rd),
        .op_rs1(op_rs1), .op_rs2(op_rs2), .done(done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_reg(input logic [4:0] base, input logic [31:0] vm, input int i);
        return (int'(base) + (vm[base] ? i : 0)) % 32;
    endfunction

    // Caller sits at a negedge; the run starts there.
    task automatic run_seq(input vec_t e, input bit disturb, input bit tail);
        int n;
        n = (e.vl < e.dvl) ? int'(e.vl) : int'(e.dvl);
        if (n > 32) n = 32;
        rd = e.rd; rs1 = e.rs1; rs2 = e.rs2; vl = e.vl; dst_vl = e.dvl;
        vec_map = e.vmap; pred_mask = e.pred; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (disturb && i == 1) begin
                // R7 / R10: inputs change and start pulses mid-run
                vec_map = ~e.vmap; pred_mask = ~e.pred; start = 1'b1;
                rd = e.rd + 5'd3; vl = 6'd1; dst_vl = 6'd1;
            end
            chk("R1 valid", int'(op_valid), 1);
            chk("R1 idx", int'(op_idx), i);
            chk("R3 R4 wen", int'(op_wen), int'(e.pred[i]));
            chk("R5 rd", int'(op_rd), exp_reg(e.rd, e.vmap, i));
            chk("R6 rs1", int'(op_rs1), exp_reg(e.rs1, e.vmap, i));
            chk("R6 rs2", int'(op_rs2), exp_reg(e.rs2, e.vmap, i));
            @(negedge clk);
            start = 1'b0;
        end
        chk("R8 R9 done", int'(done), 1);
        chk("R8 idle at done", int'(op_valid), 0);
        if (tail) begin
            @(negedge clk);
            chk("R8 pulse", int'(done), 0);
            chk("R8 stays idle", int'(op_valid), 0);
        end
    endtask

    initial begin
        #(20 * 20000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        vec_t z;
        repeat (3) @(negedge clk);
        // R12
        chk("R12 valid", int'(op_valid), 0);
        chk("R12 wen", int'(op_wen), 0);
        chk("R12 done", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 idle after reset", int'(op_valid), 0);

        // R1 R2 R3 R5 R6 table walk
        for (int k = 0; k < NV; k++) run_seq(TBL[k], 1'b0, 1'b1);

        // R7 R10: disturbance mid-run
        run_seq(TBL[1], 1'b1, 1'b1);
        run_seq(TBL[0], 1'b1, 1'b1);

        // R9 zero length
        z = TBL[0]; z.vl = 6'd0;
        run_seq(z, 1'b0, 1'b1);
        z = TBL[2]; z.dvl = 6'd0;
        run_seq(z, 1'b0, 1'b1);

        // R11 start in the done cycle, including after a zero-length run
        run_seq(TBL[3], 1'b0, 1'b0);
        run_seq(TBL[5], 1'b0, 1'b0);
        z = TBL[1]; z.vl = 6'd0;
        run_seq(z, 1'b0, 1'b0);
        run_seq(TBL[2], 1'b0, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule